// File: doc/BRIEF.md
# 8x8 Matrix-Product DCT Engine

The block computes the two-dimensional forward discrete cosine transform of one 8x8 block of signed 16-bit samples. It forms the transform as two integer matrix products, F = K·f·Kᵀ. K is a cosine matrix scaled by 128 and rounded to integers. One multiply-accumulate unit runs under a three-level loop sequencer and does all of the arithmetic. There is no divider and no floating-point logic.

The user writes the 64 samples through an addressed load port and pulses `start`. The engine then runs the first product (K times the block) into an internal 64-entry scratch buffer. The second product multiplies that buffer by the transpose of K, which it gets by reading the same coefficient table with its two indices exchanged. After each product every sum is rounded by adding 64, shifted right arithmetically by 7 and clamped to the signed 16-bit range. When the last result has been stored, `done` pulses for one cycle, and the 64 coefficients can then be read back through an addressed read port.

Top module: `dct_matmul_engine`

## Requirements
- R1: After reset `busy`, `done` and `rd_data` are all 0.
- R2: With `in_wr` high and `busy` low, `in_data` is stored as sample f[m][n] at `in_addr` = 8·m + n. A write while `busy` is high is ignored, and later transforms still use the stored block.
- R3: A `start` sampled while `busy` is low begins a transform, and `busy` is high from the next cycle until the cycle in which `done` is high.
- R4: A `start` sampled while `busy` is high is ignored: the running transform is not restarted, it produces exactly one `done`, and its results are unchanged.
- R5: The coefficient matrix is K[u][n] = 45 for u = 0 and round(64·cos((2n+1)·u·π/16)) for u = 1..7. Rounding is to nearest.
- R6: The first pass forms T[u][n] = clamp16((Σm K[u][m]·f[m][n] + 64) >>> 7).
- R7: The second pass forms F[u][v] = clamp16((Σn T[u][n]·K[v][n] + 64) >>> 7). clamp16 limits a value to the range −32768..32767.
- R8: `done` is high for exactly one cycle, 2·8³+3 = 1027 cycles after the cycle in which `start` was accepted. `busy` is low in that cycle.
- R9: When `busy` is low, `rd_data` shows F[u][v] for `rd_addr` = 8·u + v one cycle after the address is presented. While `busy` is high, `rd_data` holds its value.
- R10: A `start` given in the cycle in which `done` is high is accepted, and a new transform with the same latency follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_wr | input | 1 | Sample write strobe |
| in_addr | input | 6 | Sample index, 8·row + column |
| in_data | input | 16 | Signed sample value |
| start | input | 1 | Begin a transform |
| busy | output | 1 | Transform in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_addr | input | 6 | Coefficient index, 8·u + v |
| rd_data | output | 16 | Signed coefficient, one cycle after the address |

## Verification
A fault in the loop sequencer, such as a wrong index order, a skipped count or a wrong pass switch, moves `done` away from cycle 1027, so it shows on the first run. A wrong operand, coefficient or accumulator clear only shows when the results are read back after `done`, and then as wrong values in whole rows or columns. Blocks with a single nonzero sample expose the coefficient table entry by entry. Full-range blocks drive the clamp at both ends. A leak from the load or start ports during a run shows as changed results or a second `done` in the same run.

// File: rtl/dct_pkg.sv
package dct_pkg;

  localparam int DCT_N  = 8;
  localparam int DCT_IW = 3;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_RUN   = 2'd1,
    SQ_DRAIN = 2'd2
  } seq_state_e;

  // round(64 * cos(k*pi/16)) for k = 0..8
  function automatic int cos_mag(input int k);
    case (k)
      0:       return 64;
      1:       return 63;
      2:       return 59;
      3:       return 53;
      4:       return 45;
      5:       return 36;
      6:       return 24;
      7:       return 12;
      default: return 0;
    endcase
  endfunction

  // Scaled cosine matrix entry; the DC row carries the 1/sqrt(2) weight.
  function automatic int coef_at(input int u, input int n);
    int k;
    if (u == 0) return 45;
    k = ((2 * n + 1) * u) % 32;
    if (k > 16) k = 32 - k;
    if (k <= 8) return cos_mag(k);
    return -cos_mag(16 - k);
  endfunction

endpackage

// File: rtl/dct_coef_rom.sv
module dct_coef_rom
  import dct_pkg::*;
#(
  parameter int IW = DCT_IW,
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic [IW-1:0]        row,
  input  logic [IW-1:0]        col,
  output logic signed [CW-1:0] q
);

  always_ff @(posedge clk) begin
    q <= CW'(coef_at(int'(row), int'(col)));
  end

endmodule

// File: rtl/dct_ram.sv
module dct_ram #(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (re) q <= mem[raddr];
  end

endmodule

// File: rtl/dct_mac.sv
module dct_mac #(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int ACCW  = 32,
  parameter int SHIFT = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 clr,
  input  logic signed [CW-1:0] a,
  input  logic signed [DW-1:0] b,
  output logic        [DW-1:0] res
);

  localparam logic signed [ACCW:0] HALF = (ACCW+1)'(64'(1) << (SHIFT - 1));
  localparam logic signed [ACCW:0] MAXV = (ACCW+1)'((64'(1) << (DW - 1)) - 1);
  localparam logic signed [ACCW:0] MINV = ~MAXV;

  logic signed [ACCW-1:0] acc;
  logic signed [ACCW-1:0] a_x, b_x, prod;
  logic signed [ACCW:0]   biased, shifted;

  assign a_x  = ACCW'(a);
  assign b_x  = ACCW'(b);
  assign prod = a_x * b_x;

  always_ff @(posedge clk) begin
    if (rst)     acc <= '0;
    else if (en) acc <= (clr ? '0 : acc) + prod;
  end

  assign biased  = {acc[ACCW-1], acc} + HALF;
  assign shifted = biased >>> SHIFT;

  always_comb begin
    if (shifted > MAXV)      res = MAXV[DW-1:0];
    else if (shifted < MINV) res = MINV[DW-1:0];
    else                     res = shifted[DW-1:0];
  end

endmodule

// File: rtl/dct_seq.sv
module dct_seq
  import dct_pkg::*;
#(
  parameter int IW = DCT_IW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  output logic            busy,
  output logic            done,
  output logic [IW-1:0]   rom_row,
  output logic [IW-1:0]   rom_col,
  output logic            in_re,
  output logic [2*IW-1:0] in_raddr,
  output logic            mid_re,
  output logic [2*IW-1:0] mid_raddr,
  output logic            mac_en,
  output logic            mac_clr,
  output logic            opnd_sel,
  output logic            mid_we,
  output logic            out_we,
  output logic [2*IW-1:0] waddr
);

  localparam int CNTW = 3 * IW + 1;

  seq_state_e st;
  logic [CNTW-1:0] cnt;
  logic [IW-1:0]   ci, cj, ck;
  logic            cpass, issue, is_final;

  logic            p1_v, p1_first, p1_last, p1_pass, p1_fin;
  logic [2*IW-1:0] p1_dst;
  logic            p2_wr, p2_pass, p2_fin;
  logic [2*IW-1:0] p2_dst;

  // loop order: inner index fastest, then column, row, pass
  assign ck    = cnt[IW-1:0];
  assign cj    = cnt[2*IW-1:IW];
  assign ci    = cnt[3*IW-1:2*IW];
  assign cpass = cnt[3*IW];

  assign issue    = (st == SQ_RUN);
  assign is_final = &cnt;
  assign busy     = (st != SQ_IDLE);

  assign rom_row   = cpass ? cj : ci;
  assign rom_col   = ck;
  assign in_re     = issue && !cpass;
  assign in_raddr  = {ck, cj};
  assign mid_re    = issue && cpass;
  assign mid_raddr = {ci, ck};

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= SQ_IDLE;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= p2_wr && p2_fin;
      case (st)
        SQ_IDLE: if (start) begin
          st  <= SQ_RUN;
          cnt <= '0;
        end
        SQ_RUN: begin
          cnt <= cnt + 1'b1;
          if (is_final) st <= SQ_DRAIN;
        end
        SQ_DRAIN: if (p2_wr && p2_fin) st <= SQ_IDLE;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p1_v <= 1'b0; p1_first <= 1'b0; p1_last <= 1'b0;
      p1_pass <= 1'b0; p1_fin <= 1'b0; p1_dst <= '0;
      p2_wr <= 1'b0; p2_pass <= 1'b0; p2_fin <= 1'b0; p2_dst <= '0;
    end else begin
      p1_v     <= issue;
      p1_first <= issue && (ck == '0);
      p1_last  <= issue && (&ck);
      p1_pass  <= cpass;
      p1_fin   <= issue && is_final;
      p1_dst   <= {ci, cj};
      p2_wr    <= p1_v && p1_last;
      p2_pass  <= p1_pass;
      p2_fin   <= p1_fin;
      p2_dst   <= p1_dst;
    end
  end

  assign mac_en   = p1_v;
  assign mac_clr  = p1_first;
  assign opnd_sel = p1_pass;
  assign mid_we   = p2_wr && !p2_pass;
  assign out_we   = p2_wr && p2_pass;
  assign waddr    = p2_dst;

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r3_start_accept: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);

  a_r4_no_restart: assert property (@(posedge clk) disable iff (rst)
    (issue && !is_final && start) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/dct_matmul_engine.sv
module dct_matmul_engine
  import dct_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int ACCW  = 32,
  parameter int SHIFT = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_wr,
  input  logic [5:0]    in_addr,
  input  logic [DW-1:0] in_data,
  input  logic          start,
  output logic          busy,
  output logic          done,
  input  logic [5:0]    rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int IW = DCT_IW;
  localparam int AW = 2 * IW;

  logic [IW-1:0]        rom_row, rom_col;
  logic                 in_re, mid_re, mac_en, mac_clr, opnd_sel;
  logic                 mid_we, out_we;
  logic [AW-1:0]        in_raddr, mid_raddr, waddr;
  logic signed [CW-1:0] coef_q;
  logic [DW-1:0]        in_q, mid_q, mac_res;
  logic signed [DW-1:0] opnd_b;

  dct_seq #(.IW(IW)) i_seq (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .rom_row(rom_row), .rom_col(rom_col),
    .in_re(in_re), .in_raddr(in_raddr),
    .mid_re(mid_re), .mid_raddr(mid_raddr),
    .mac_en(mac_en), .mac_clr(mac_clr), .opnd_sel(opnd_sel),
    .mid_we(mid_we), .out_we(out_we), .waddr(waddr)
  );

  dct_coef_rom #(.IW(IW), .CW(CW)) i_rom (
    .clk(clk), .row(rom_row), .col(rom_col), .q(coef_q)
  );

  dct_ram #(.DW(DW), .AW(AW)) i_in_ram (
    .clk(clk), .rst(rst),
    .we(in_wr && !busy), .waddr(in_addr), .wdata(in_data),
    .re(in_re), .raddr(in_raddr), .q(in_q)
  );

  dct_ram #(.DW(DW), .AW(AW)) i_mid_ram (
    .clk(clk), .rst(rst),
    .we(mid_we), .waddr(waddr), .wdata(mac_res),
    .re(mid_re), .raddr(mid_raddr), .q(mid_q)
  );

  dct_ram #(.DW(DW), .AW(AW)) i_out_ram (
    .clk(clk), .rst(rst),
    .we(out_we), .waddr(waddr), .wdata(mac_res),
    .re(!busy), .raddr(rd_addr), .q(rd_data)
  );

  assign opnd_b = opnd_sel ? mid_q : in_q;

  dct_mac #(.DW(DW), .CW(CW), .ACCW(ACCW), .SHIFT(SHIFT)) i_mac (
    .clk(clk), .rst(rst), .en(mac_en), .clr(mac_clr),
    .a(coef_q), .b(opnd_b), .res(mac_res)
  );

  a_r9_rd_hold: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(rd_data));

endmodule

// File: tb/test_dct_matmul_engine.sv
`timescale 1ns/1ps
module test_dct_matmul_engine;

  localparam int LAT = 2 * 8 * 8 * 8 + 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_wr = 1'b0;
  logic [5:0]  in_addr = '0;
  logic [15:0] in_data = '0;
  logic        start = 1'b0;
  logic        busy, done;
  logic [5:0]  rd_addr = '0;
  logic [15:0] rd_data;

  int checks = 0, errors = 0, done_cnt = 0, cyc = 0;
  int pix [64];
  int expf [64];
  int cm [8][8];
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dct_matmul_engine i_dct_matmul_engine (
    .clk(clk), .rst(rst), .in_wr(in_wr), .in_addr(in_addr), .in_data(in_data),
    .start(start), .busy(busy), .done(done), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always @(negedge clk) if (done) done_cnt++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint clamp16(input longint x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  // R5: coefficient matrix from real cosine, rounded to nearest
  task automatic build_coefs();
    real pi = 3.14159265358979;
    for (int u = 0; u < 8; u++)
      for (int n = 0; n < 8; n++) begin
        real x;
        if (u == 0) x = 128.0 / (2.0 * $sqrt(2.0));
        else        x = 64.0 * $cos((2.0 * n + 1.0) * u * pi / 16.0);
        cm[u][n] = int'($floor(x + 0.5));
      end
  endtask

  // R6 and R7 reference
  task automatic model();
    longint t [64];
    for (int u = 0; u < 8; u++)
      for (int n = 0; n < 8; n++) begin
        longint s = 0;
        for (int m = 0; m < 8; m++) s += longint'(cm[u][m]) * longint'(pix[m*8+n]);
        t[u*8+n] = clamp16((s + 64) >>> 7);
      end
    for (int u = 0; u < 8; u++)
      for (int v = 0; v < 8; v++) begin
        longint s = 0;
        for (int n = 0; n < 8; n++) s += t[u*8+n] * longint'(cm[v][n]);
        expf[u*8+v] = int'(clamp16((s + 64) >>> 7));
      end
  endtask

  task automatic load();
    for (int a = 0; a < 64; a++) begin
      @(negedge clk);
      in_wr = 1'b1; in_addr = 6'(a); in_data = 16'(pix[a]);
    end
    @(negedge clk);
    in_wr = 1'b0;
  endtask

  task automatic run(input bit poke, input bit chain);
    int lat, d0;
    logic [15:0] hold;
    bit changed;
    d0 = done_cnt;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy === 1'b1, "R3 busy after start", busy, 1);
    hold = rd_data; changed = 1'b0; lat = 1;
    while (!done && lat < 2000) begin
      if (rd_data !== hold) changed = 1'b1;
      if (poke && lat == 300) begin
        start = 1'b1; in_wr = 1'b1; in_addr = 6'd0; in_data = 16'h1234;
      end else begin
        start = 1'b0; in_wr = 1'b0;
      end
      rd_addr = 6'(lat);
      @(negedge clk); lat++;
    end
    check(lat == LAT, "R8 latency", lat, LAT);
    check(!changed, "R9 rd_data held while busy", changed, 0);
    check(busy === 1'b0, "R8 busy low with done", busy, 0);
    if (chain) begin
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      check(done === 1'b0, "R8 done one cycle", done, 0);
      check(busy === 1'b1, "R10 start in done cycle accepted", busy, 1);
      lat = 1;
      while (!done && lat < 2000) begin
        @(negedge clk); lat++;
      end
      check(lat == LAT, "R10 chained latency", lat, LAT);
      @(negedge clk);
    end else begin
      @(negedge clk);
      check(done === 1'b0, "R8 done one cycle", done, 0);
    end
    check(done_cnt - d0 == (chain ? 2 : 1), "R4 done count", done_cnt - d0, chain ? 2 : 1);
  endtask

  task automatic read_check(input string tag);
    for (int a = 0; a < 64; a++) begin
      @(negedge clk); rd_addr = 6'(a);
      @(negedge clk);
      check($signed(rd_data) == expf[a], tag, $signed(rd_data), expf[a]);
    end
  endtask

  task automatic full(input string tag);
    model(); load(); run(1'b0, 1'b0); read_check(tag);
  endtask

  initial begin
    void'($urandom(32'd1234));
    build_coefs();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check(busy === 1'b0, "R1 busy reset", busy, 0);
    check(done === 1'b0, "R1 done reset", done, 0);
    check(rd_data === 16'h0, "R1 rd_data reset", rd_data, 0);

    // zeros
    for (int a = 0; a < 64; a++) pix[a] = 0;
    full("R6 R7 zero block");

    // constant block: DC only, hand value 790
    for (int a = 0; a < 64; a++) pix[a] = 100;
    model(); load(); run(1'b0, 1'b0);
    for (int a = 0; a < 64; a++) begin
      @(negedge clk); rd_addr = 6'(a);
      @(negedge clk);
      check($signed(rd_data) == (a == 0 ? 790 : 0), "R5 R7 constant block",
            $signed(rd_data), a == 0 ? 790 : 0);
    end

    // single sample exposes the coefficient table
    for (int a = 0; a < 64; a++) pix[a] = 0;
    pix[0] = 128;
    full("R5 single sample");

    // small-range random blocks
    for (int b = 0; b < 3; b++) begin
      for (int a = 0; a < 64; a++) pix[a] = int'($urandom_range(255)) - 128;
      full("R6 R7 random block");
    end

    // full-range random and extremes drive the clamp
    for (int a = 0; a < 64; a++) pix[a] = int'($urandom_range(65535)) - 32768;
    full("R7 full range");
    for (int a = 0; a < 64; a++) pix[a] = 32767;
    full("R7 clamp high");
    for (int a = 0; a < 64; a++) pix[a] = -32768;
    full("R7 clamp low");

    // writes and start during a run are ignored
    for (int a = 0; a < 64; a++) pix[a] = int'($urandom_range(511)) - 256;
    model(); load();
    run(1'b1, 1'b0);
    read_check("R4 results after start while busy");
    run(1'b0, 1'b0);
    read_check("R2 stored block kept after busy write");

    // back-to-back start in the done cycle
    run(1'b0, 1'b1);
    read_check("R10 chained results");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule